// File: doc/BRIEF.md
# Dual-Path Byte-Lane Data Memory Access Unit

This unit sits between the address-generation stage of a 16-bit processor datapath and its data memory. The memory is a word-organised register array built from two byte-wide lanes. Both lanes share one word index and each has its own write enable. Two request streams reach it. The X stream reads and writes, in byte or word size. The Y stream serves the second operand fetch of multiply-accumulate style operations, so it reads whole words only. Every request carries a 16-bit byte address and an optional post-increment. Every response returns the data and the updated pointer one cycle after the request is accepted.

Module parameters set the implemented address windows. The X window is the whole backing array. The Y window is a slice of it. An access outside its path's window does not fault silently: a read returns 0x0000, a write is dropped, and the response carries a trap flag. A shared address-error pin also pulses for one cycle.

Each path is a valid/ready stream with a single response register. A request is accepted when `*_req_valid` and `*_req_ready` are both high. `*_req_ready` is high whenever the response register is empty or its content is being taken in the same cycle. A response stays on the outputs, unchanged, until `*_rsp_ready` takes it. The address-error pin is plain control and is not back-pressured.

Top module: `dspace_access_unit`

## Requirements
- R1: An X word read returns the 16-bit word at the aligned word address, ignoring address bit 0, in the cycle after acceptance.
- R2: An X byte read returns the byte selected by address bit 0 (0 selects bits 7:0 of the stored word, 1 selects bits 15:8) on rdata bits 7:0, with rdata bits 15:8 equal to zero.
- R3: An X byte write stores wdata bits 7:0 only into the lane that address bit 0 selects (0 selects the low lane, 1 the high lane). The other lane keeps its value.
- R4: An X word write stores all 16 bits of wdata at the aligned word address, ignoring address bit 0. Every write response returns rdata 0x0000.
- R5: The Y path performs word reads only. For the same in-window address it returns the same word that an X word read returns.
- R6: The returned pointer is the request address plus 1 for a post-incremented byte access and plus 2 for a post-incremented word access (all Y accesses count as word accesses). Without post-increment it is the request address. The sum wraps modulo 2^16, and the step applies to faulting accesses too.
- R7: An X access with an address outside [X_LO, X_HI) returns rdata 0x0000 with the trap flag set. If the access is a write, it leaves the memory unchanged.
- R8: A Y access outside [Y_LO, Y_HI) returns 0x0000 with the trap flag set, even when the address lies inside the X window.
- R9: addr_err is high for exactly the first cycle in which a faulting response is presented, on either path, and is low in every other cycle.
- R10: While a response is valid and its ready input is low, the response holds all of its fields, and the request ready output of that path is low.
- R11: After reset no response is valid, addr_err is low and every memory word reads as zero.
- R12: When an X write and a Y read to the same word are accepted in the same cycle, the Y read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_req_valid | input | 1 | X request present |
| x_req_ready | output | 1 | X request can be taken |
| x_req_addr | input | 16 | X byte address |
| x_req_byte | input | 1 | 1 selects a byte access, 0 a word access |
| x_req_write | input | 1 | 1 selects a write, 0 a read |
| x_req_incr | input | 1 | Post-increment the pointer |
| x_req_wdata | input | 16 | X write data (bits 7:0 for byte writes) |
| x_rsp_valid | output | 1 | X response present |
| x_rsp_ready | input | 1 | X response taken |
| x_rsp_rdata | output | 16 | X read data |
| x_rsp_ptr | output | 16 | X updated pointer |
| x_rsp_trap | output | 1 | X access was outside the X window |
| y_req_valid | input | 1 | Y request present |
| y_req_ready | output | 1 | Y request can be taken |
| y_req_addr | input | 16 | Y byte address |
| y_req_incr | input | 1 | Post-increment the pointer by 2 |
| y_rsp_valid | output | 1 | Y response present |
| y_rsp_ready | input | 1 | Y response taken |
| y_rsp_rdata | output | 16 | Y read word |
| y_rsp_ptr | output | 16 | Y updated pointer |
| y_rsp_trap | output | 1 | Y access was outside the Y window |
| addr_err | output | 1 | One-cycle address-error pulse |

## Verification
The bench builds the unit with its defaults: a 128-byte X window at 0x0800 (64 words) and a Y window covering the upper half of it, 0x0840 to 0x087F. Because the array is small, random addresses land on stored words often. Byte writes followed by reads then expose lane mix-ups. Addresses drawn a few bytes past both ends of each window reach both edges of both windows, along with the band that is inside X but outside Y. Directed cases add pointer wrap at 0xFFFF, a same-word X write against a Y read, and a held response under back-pressure.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
  typedef logic [15:0] addr_t;
  typedef logic [15:0] word_t;

  typedef struct packed {
    word_t rdata;
    addr_t ptr;
    logic  trap;
  } rsp_t;

  function automatic addr_t step_ptr(input addr_t a, input logic incr, input logic is_byte);
    if (!incr) return a;
    return is_byte ? a + 16'd1 : a + 16'd2;
  endfunction
endpackage

// File: rtl/dm_window.sv
module dm_window #(
  parameter int unsigned LO    = 32'h0800,
  parameter int unsigned HI    = 32'h0880,
  parameter int unsigned BASE  = 32'h0800,
  parameter int unsigned IDX_W = 6
) (
  input  logic [15:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [15:0] BASE_W = 16'(BASE / 2);

  always_comb begin
    hit = (32'(addr) >= LO) && (32'(addr) < HI);
    idx = IDX_W'({1'b0, addr[15:1]} - BASE_W);
  end
endmodule

// File: rtl/dm_lane_array.sv
module dm_lane_array #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lane_we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [15:0]      w_data,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [15:0]      ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [15:0]      rb_data
);
  for (genvar L = 0; L < 2; L++) begin : g_lane
    logic [7:0] cells [WORDS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < int'(WORDS); i++) cells[i] <= 8'h00;
      end else if (lane_we[L]) begin
        cells[w_idx] <= w_data[8*L +: 8];
      end
    end

    assign ra_data[8*L +: 8] = cells[ra_idx];
    assign rb_data[8*L +: 8] = cells[rb_idx];
  end
endmodule

// File: rtl/dm_rsp_stage.sv
module dm_rsp_stage
  import dspace_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  rsp_t in_data,
  output logic out_valid,
  input  logic out_ready,
  output rsp_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/dspace_access_unit.sv
module dspace_access_unit
  import dspace_pkg::*;
#(
  parameter int unsigned X_LO = 32'h0800,
  parameter int unsigned X_HI = 32'h0880,
  parameter int unsigned Y_LO = 32'h0840,
  parameter int unsigned Y_HI = 32'h0880
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        x_req_valid,
  output logic        x_req_ready,
  input  logic [15:0] x_req_addr,
  input  logic        x_req_byte,
  input  logic        x_req_write,
  input  logic        x_req_incr,
  input  logic [15:0] x_req_wdata,
  output logic        x_rsp_valid,
  input  logic        x_rsp_ready,
  output logic [15:0] x_rsp_rdata,
  output logic [15:0] x_rsp_ptr,
  output logic        x_rsp_trap,
  input  logic        y_req_valid,
  output logic        y_req_ready,
  input  logic [15:0] y_req_addr,
  input  logic        y_req_incr,
  output logic        y_rsp_valid,
  input  logic        y_rsp_ready,
  output logic [15:0] y_rsp_rdata,
  output logic [15:0] y_rsp_ptr,
  output logic        y_rsp_trap,
  output logic        addr_err
);
  localparam int unsigned WORDS = (X_HI - X_LO) / 2;
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic             x_hit, y_hit, x_acc, y_acc;
  logic [IDX_W-1:0] x_idx, y_idx;
  logic [15:0]      x_word, y_word, x_rd;
  logic [1:0]       lane_we;
  logic [15:0]      w_data;
  rsp_t             x_in, y_in, x_out, y_out;
  logic             err_q;

  dm_window #(.LO(X_LO), .HI(X_HI), .BASE(X_LO), .IDX_W(IDX_W)) u_xwin (
    .addr(x_req_addr), .hit(x_hit), .idx(x_idx));
  dm_window #(.LO(Y_LO), .HI(Y_HI), .BASE(X_LO), .IDX_W(IDX_W)) u_ywin (
    .addr(y_req_addr), .hit(y_hit), .idx(y_idx));

  assign x_acc = x_req_valid && x_req_ready;
  assign y_acc = y_req_valid && y_req_ready;

  always_comb begin
    lane_we[0] = x_acc && x_req_write && x_hit && (!x_req_byte || !x_req_addr[0]);
    lane_we[1] = x_acc && x_req_write && x_hit && (!x_req_byte ||  x_req_addr[0]);
    w_data     = x_req_byte ? {x_req_wdata[7:0], x_req_wdata[7:0]} : x_req_wdata;
  end

  dm_lane_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .w_idx(x_idx), .w_data(w_data),
    .ra_idx(x_idx), .ra_data(x_word), .rb_idx(y_idx), .rb_data(y_word));

  always_comb begin
    if (!x_hit || x_req_write) x_rd = 16'h0000;
    else if (x_req_byte)       x_rd = {8'h00, x_req_addr[0] ? x_word[15:8] : x_word[7:0]};
    else                       x_rd = x_word;
    x_in = '{rdata: x_rd,
             ptr:   step_ptr(x_req_addr, x_req_incr, x_req_byte),
             trap:  !x_hit};
    y_in = '{rdata: y_hit ? y_word : 16'h0000,
             ptr:   step_ptr(y_req_addr, y_req_incr, 1'b0),
             trap:  !y_hit};
  end

  dm_rsp_stage u_xrsp (
    .clk(clk), .rst_n(rst_n), .in_valid(x_req_valid), .in_ready(x_req_ready),
    .in_data(x_in), .out_valid(x_rsp_valid), .out_ready(x_rsp_ready), .out_data(x_out));
  dm_rsp_stage u_yrsp (
    .clk(clk), .rst_n(rst_n), .in_valid(y_req_valid), .in_ready(y_req_ready),
    .in_data(y_in), .out_valid(y_rsp_valid), .out_ready(y_rsp_ready), .out_data(y_out));

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (x_acc && !x_hit) || (y_acc && !y_hit);
  end

  assign addr_err    = err_q;
  assign x_rsp_rdata = x_out.rdata;
  assign x_rsp_ptr   = x_out.ptr;
  assign x_rsp_trap  = x_out.trap;
  assign y_rsp_rdata = y_out.rdata;
  assign y_rsp_ptr   = y_out.ptr;
  assign y_rsp_trap  = y_out.trap;
endmodule

// File: rtl/dspace_access_unit_chk.sv
module dspace_access_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        x_req_valid,
  input logic        x_req_ready,
  input logic [15:0] x_req_addr,
  input logic        x_req_byte,
  input logic        x_req_write,
  input logic        x_req_incr,
  input logic        x_rsp_valid,
  input logic        x_rsp_ready,
  input logic [15:0] x_rsp_rdata,
  input logic [15:0] x_rsp_ptr,
  input logic        x_rsp_trap,
  input logic        y_req_valid,
  input logic        y_req_ready,
  input logic [15:0] y_req_addr,
  input logic        y_req_incr,
  input logic        y_rsp_valid,
  input logic        y_rsp_ready,
  input logic [15:0] y_rsp_ptr,
  input logic [15:0] y_rsp_rdata,
  input logic        y_rsp_trap,
  input logic        addr_err
);
  // R2
  a_r2_byte_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    x_req_valid && x_req_ready && x_req_byte && !x_req_write |=> x_rsp_rdata[15:8] == 8'h00);
  // R4
  a_r4_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    x_req_valid && x_req_ready && x_req_write |=> x_rsp_rdata == 16'h0000);
  // R6
  a_r6_x_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    x_req_valid && x_req_ready |=> x_rsp_valid &&
      x_rsp_ptr == $past(x_req_addr) + ($past(x_req_incr) ? ($past(x_req_byte) ? 16'd1 : 16'd2) : 16'd0));
  a_r6_y_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    y_req_valid && y_req_ready |=> y_rsp_valid &&
      y_rsp_ptr == $past(y_req_addr) + ($past(y_req_incr) ? 16'd2 : 16'd0));
  // R7
  a_r7_x_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    x_rsp_valid && x_rsp_trap |-> x_rsp_rdata == 16'h0000);
  // R8
  a_r8_y_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    y_rsp_valid && y_rsp_trap |-> y_rsp_rdata == 16'h0000);
  // R9
  a_r9_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (x_rsp_valid && x_rsp_trap) || (y_rsp_valid && y_rsp_trap));
  // R10
  a_r10_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    x_rsp_valid && !x_rsp_ready |=> x_rsp_valid && $stable(x_rsp_rdata) && $stable(x_rsp_ptr) && $stable(x_rsp_trap));
  a_r10_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    y_rsp_valid && !y_rsp_ready |=> y_rsp_valid && $stable(y_rsp_rdata) && $stable(y_rsp_ptr) && $stable(y_rsp_trap));
  a_r10_x_stall: assert property (@(posedge clk) disable iff (!rst_n)
    x_rsp_valid && !x_rsp_ready |-> !x_req_ready);
endmodule

bind dspace_access_unit dspace_access_unit_chk chk_i (.*);

// File: tb/dspace_access_unit_tb_top.sv
module dspace_access_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned X_LO = 32'h0800, X_HI = 32'h0880;
  localparam int unsigned Y_LO = 32'h0840, Y_HI = 32'h0880;
  localparam int WORDS = int'((X_HI - X_LO) / 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic x_req_valid = 0, x_req_byte = 0, x_req_write = 0, x_req_incr = 0, x_rsp_ready = 1;
  logic [15:0] x_req_addr = 0, x_req_wdata = 0;
  logic y_req_valid = 0, y_req_incr = 0, y_rsp_ready = 1;
  logic [15:0] y_req_addr = 0;
  logic x_req_ready, x_rsp_valid, x_rsp_trap, y_req_ready, y_rsp_valid, y_rsp_trap, addr_err;
  logic [15:0] x_rsp_rdata, x_rsp_ptr, y_rsp_rdata, y_rsp_ptr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dspace_access_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_x(input logic [15:0] a);
    return 32'(a) >= X_LO && 32'(a) < X_HI;
  endfunction
  function automatic bit in_y(input logic [15:0] a);
    return 32'(a) >= Y_LO && 32'(a) < Y_HI;
  endfunction
  function automatic int widx(input logic [15:0] a);
    return (int'(a) - int'(X_LO)) / 2;
  endfunction
  function automatic logic [15:0] nptr(input logic [15:0] a, input logic inc, input logic bt);
    return inc ? a + (bt ? 16'd1 : 16'd2) : a;
  endfunction

  task automatic x_op(input logic wr, input logic bt, input logic inc,
                      input logic [15:0] a, input logic [15:0] wd);
    logic [15:0] exp_rd;
    string tag;
    bit hit;
    hit = in_x(a);
    exp_rd = 16'h0;
    if (hit && !wr) begin
      if (bt) exp_rd = {8'h00, a[0] ? model[widx(a)][15:8] : model[widx(a)][7:0]};
      else    exp_rd = model[widx(a)];
    end
    tag = !hit ? "R7" : (bt ? (wr ? "R3" : "R2") : (wr ? "R4" : "R1"));
    @(negedge clk);
    x_req_valid = 1; x_req_write = wr; x_req_byte = bt; x_req_incr = inc;
    x_req_addr = a; x_req_wdata = wd;
    @(negedge clk);
    x_req_valid = 0;
    if (hit && wr) begin
      if (!bt)      model[widx(a)] = wd;
      else if (a[0]) model[widx(a)][15:8] = wd[7:0];
      else           model[widx(a)][7:0]  = wd[7:0];
    end
    chk(tag, {31'b0, x_rsp_valid}, 32'd1);
    chk(tag, {16'b0, x_rsp_rdata}, {16'b0, exp_rd});
    chk(tag, {31'b0, x_rsp_trap}, {31'b0, !hit});
    chk("R6", {16'b0, x_rsp_ptr}, {16'b0, nptr(a, inc, bt)});
    chk("R9", {31'b0, addr_err}, {31'b0, !hit});
  endtask

  task automatic y_op(input logic inc, input logic [15:0] a);
    bit hit;
    hit = in_y(a);
    @(negedge clk);
    y_req_valid = 1; y_req_incr = inc; y_req_addr = a;
    @(negedge clk);
    y_req_valid = 0;
    chk(hit ? "R5" : "R8", {31'b0, y_rsp_valid}, 32'd1);
    chk(hit ? "R5" : "R8", {16'b0, y_rsp_rdata}, {16'b0, hit ? model[widx(a)] : 16'h0});
    chk("R8", {31'b0, y_rsp_trap}, {31'b0, !hit});
    chk("R6", {16'b0, y_rsp_ptr}, {16'b0, nptr(a, inc, 1'b0)});
    chk("R9", {31'b0, addr_err}, {31'b0, !hit});
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] old;
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", {31'b0, x_rsp_valid}, 0);
    chk("R11", {31'b0, y_rsp_valid}, 0);
    chk("R11", {31'b0, addr_err}, 0);
    chk("R10", {31'b0, x_req_ready}, 1);
    x_op(0, 0, 0, 16'(X_LO + 6), 0);
    y_op(0, 16'(Y_LO + 4));

    // directed lanes: R3, R4, R1 with bit 0 ignored
    x_op(1, 0, 1, 16'(X_LO + 11), 16'hA1B2);
    x_op(0, 0, 0, 16'(X_LO + 10), 0);
    x_op(1, 1, 1, 16'(X_LO + 11), 16'h00C3);
    x_op(0, 0, 0, 16'(X_LO + 10), 0);
    x_op(1, 1, 0, 16'(X_LO + 10), 16'hFFD4);
    x_op(0, 1, 1, 16'(X_LO + 10), 0);
    x_op(0, 1, 1, 16'(X_LO + 11), 0);
    // edges of windows, R7 write discarded
    x_op(1, 0, 0, 16'(X_HI), 16'h5555);
    x_op(1, 0, 0, 16'(X_LO - 2), 16'h6666);
    x_op(0, 0, 0, 16'(X_HI - 2), 0);
    x_op(0, 0, 0, 16'(X_LO), 0);
    // R9 pulse is one cycle
    @(negedge clk);
    chk("R9", {31'b0, addr_err}, 0);
    // R8 inside X, outside Y
    x_op(1, 0, 0, 16'(Y_LO - 2), 16'h7777);
    y_op(1, 16'(Y_LO - 2));
    y_op(1, 16'(Y_HI));
    x_op(1, 0, 0, 16'(Y_LO), 16'h1234);
    y_op(1, 16'(Y_LO + 1));
    // R6 wrap
    x_op(0, 1, 1, 16'hFFFF, 0);
    y_op(1, 16'hFFFE);

    // R12 same-cycle X write and Y read to the same word
    old = model[widx(16'(Y_LO + 8))];
    @(negedge clk);
    x_req_valid = 1; x_req_write = 1; x_req_byte = 0; x_req_incr = 0;
    x_req_addr = 16'(Y_LO + 8); x_req_wdata = ~old;
    y_req_valid = 1; y_req_incr = 0; y_req_addr = 16'(Y_LO + 8);
    @(negedge clk);
    x_req_valid = 0; y_req_valid = 0;
    model[widx(16'(Y_LO + 8))] = ~old;
    chk("R12", {16'b0, y_rsp_rdata}, {16'b0, old});
    y_op(0, 16'(Y_LO + 8));

    // R10 back-pressure
    x_rsp_ready = 0;
    @(negedge clk);
    x_req_valid = 1; x_req_write = 0; x_req_byte = 0; x_req_incr = 1;
    x_req_addr = 16'(Y_LO + 8);
    @(negedge clk);
    x_req_addr = 16'(X_LO);
    x_req_incr = 0;
    chk("R10", {31'b0, x_req_ready}, 0);
    @(negedge clk);
    chk("R10", {31'b0, x_rsp_valid}, 1);
    chk("R10", {16'b0, x_rsp_rdata}, {16'b0, ~old});
    chk("R10", {16'b0, x_rsp_ptr}, {16'b0, 16'(Y_LO + 10)});
    x_req_valid = 0;
    x_rsp_ready = 1;
    @(negedge clk);
    chk("R10", {31'b0, x_rsp_valid}, 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      if ($urandom_range(0, 3) == 0) begin
        a = 16'(Y_LO - 8 + $urandom_range(0, (Y_HI - Y_LO) + 15));
        y_op(1'($urandom_range(0, 1)), a);
      end else begin
        a = 16'(X_LO - 8 + $urandom_range(0, (X_HI - X_LO) + 15));
        x_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             a, 16'($urandom()));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule